// File: doc/BRIEF.md
# Bit-Slice Arithmetic Logic Unit with Signed Compare

This block is a purely combinational arithmetic logic unit assembled from one-bit slices. Every slice holds a full adder, an AND gate, an OR gate and a four-way result selector. Each slice can also invert either of its operand bits. The low slices are all copies of one module. The top slice is a separate module that also works out the signed comparison flag and the overflow flag. The carry ripples from bit 0 upward. The comparison flag from the top slice is routed back to the compare input of bit 0, so a set-on-less-than gives a result of one or zero.

A 4-bit operation code picks the function. The code holds an A-invert bit, a B-invert bit and a 2-bit result selector. When B-invert is set, it also forces the carry into bit 0, so the adder subtracts in two's complement. The block reports a result, the adder's carry-out, a signed overflow flag that is valid only for add and subtract, and a flag for a zero result.

Top module: `bslice_alu`

## Requirements
- R1: Operation code 4'b0000 gives the bitwise AND of the two operands.
- R2: Operation code 4'b0001 gives the bitwise OR of the two operands.
- R3: Operation code 4'b0010 gives the sum of the two operands modulo 2^WIDTH. In this mode the carry output is the unsigned carry out of the sum.
- R4: Operation code 4'b0110 gives A minus B modulo 2^WIDTH. In this mode the carry output is 1 exactly when A is greater than or equal to B as unsigned numbers.
- R5: Operation code 4'b0111 gives 1 when A is less than B as signed two's-complement numbers, and 0 otherwise. The answer is also correct when A minus B overflows. All result bits above bit 0 are zero in this mode.
- R6: For codes 4'b0010 and 4'b0110, the overflow output is 1 exactly when the signed two's-complement result does not fit in WIDTH bits.
- R7: For codes 4'b0000, 4'b0001 and 4'b0111, the overflow output is 0.
- R8: The zero output is 1 exactly when every result bit is 0, for every operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 4 | Operation code {A-invert, B-invert, select[1:0]} |
| result_o | output | WIDTH | Selected result |
| carry_o | output | 1 | Carry out of the top slice's adder |
| overflow_o | output | 1 | Signed overflow, add and subtract only |
| zero_o | output | 1 | All result bits are zero |

## Verification
The checker samples the ports in combinational processes. It assumes that the operation code holds one of the five defined values whenever it checks an arithmetic or compare property, and it checks those properties only under a decode of that code. The bench drives only the five defined codes. It changes the operands and the code only between clock edges, so every check sees settled values. For each code, the bench sweeps all operand pairs. This covers signed overflow in both directions, borrows, and zero results.

// File: rtl/bslice_alu_pkg.sv
package bslice_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 4'b0000,
        OP_OR  = 4'b0001,
        OP_ADD = 4'b0010,
        OP_SUB = 4'b0110,
        OP_SLT = 4'b0111
    } alu_op_e;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } res_sel_e;

    typedef struct packed {
        logic     inv_a;
        logic     inv_b;
        res_sel_e sel;
    } op_fields_t;

    function automatic op_fields_t split_op(input logic [OP_W-1:0] code);
        return op_fields_t'(code);
    endfunction

    function automatic logic is_arith(input op_fields_t f);
        return (f.sel == SEL_SUM);
    endfunction

endpackage

// File: rtl/bslice_gates.sv
module gate_xor2 (
    input  logic a,
    input  logic b,
    output logic y
);
    assign y = a ^ b;
endmodule

module gate_fa (
    input  logic a,
    input  logic b,
    input  logic cin,
    output logic sum,
    output logic cout
);
    logic p;
    gate_xor2 u_p (.a(a), .b(b), .y(p));
    gate_xor2 u_s (.a(p), .b(cin), .y(sum));
    assign cout = (a & b) | (p & cin);
endmodule

module gate_mux4 (
    input  logic       d0,
    input  logic       d1,
    input  logic       d2,
    input  logic       d3,
    input  logic [1:0] sel,
    output logic       y
);
    logic lo, hi;
    assign lo = (d0 & ~sel[0]) | (d1 & sel[0]);
    assign hi = (d2 & ~sel[0]) | (d3 & sel[0]);
    assign y  = (lo & ~sel[1]) | (hi & sel[1]);
endmodule

// File: rtl/bslice_slices.sv
module alu_bit
    import bslice_alu_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic       cin,
    input  logic       less,
    input  op_fields_t ctl,
    output logic       res,
    output logic       cout
);
    logic aa, bb, sum;

    gate_xor2 u_ia (.a(a), .b(ctl.inv_a), .y(aa));
    gate_xor2 u_ib (.a(b), .b(ctl.inv_b), .y(bb));
    gate_fa   u_fa (.a(aa), .b(bb), .cin(cin), .sum(sum), .cout(cout));
    gate_mux4 u_mx (.d0(aa & bb), .d1(aa | bb), .d2(sum), .d3(less),
                    .sel(ctl.sel), .y(res));
endmodule

module alu_bit_msb
    import bslice_alu_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic       cin,
    input  logic       less,
    input  op_fields_t ctl,
    output logic       res,
    output logic       cout,
    output logic       set,
    output logic       ovf
);
    logic aa, bb, sum, ovf_raw;

    gate_xor2 u_ia (.a(a), .b(ctl.inv_a), .y(aa));
    gate_xor2 u_ib (.a(b), .b(ctl.inv_b), .y(bb));
    gate_fa   u_fa (.a(aa), .b(bb), .cin(cin), .sum(sum), .cout(cout));
    gate_mux4 u_mx (.d0(aa & bb), .d1(aa | bb), .d2(sum), .d3(less),
                    .sel(ctl.sel), .y(res));

    // Signed overflow: the carry into the sign bit differs from the carry out.
    gate_xor2 u_ov (.a(cin), .b(cout), .y(ovf_raw));
    // The true sign of A-B is the sum sign, corrected by the overflow.
    gate_xor2 u_st (.a(sum), .b(ovf_raw), .y(set));
    assign ovf = ovf_raw & ctl.sel[1] & ~ctl.sel[0];
endmodule

// File: rtl/bslice_alu.sv
module bslice_alu
    import bslice_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [OP_W-1:0]  op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             overflow_o,
    output logic             zero_o
);
    localparam int TOP = WIDTH - 1;

    op_fields_t       ctl;
    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] less;
    logic             set_w;

    assign ctl      = split_op(op_i);
    assign carry[0] = ctl.inv_b;
    assign less     = {{(WIDTH-1){1'b0}}, set_w};

    genvar i;
    generate
        for (i = 0; i < TOP; i++) begin : g_low
            alu_bit u_bit (
                .a(a_i[i]), .b(b_i[i]), .cin(carry[i]), .less(less[i]),
                .ctl(ctl), .res(result_o[i]), .cout(carry[i+1])
            );
        end
    endgenerate

    alu_bit_msb u_msb (
        .a(a_i[TOP]), .b(b_i[TOP]), .cin(carry[TOP]), .less(less[TOP]),
        .ctl(ctl), .res(result_o[TOP]), .cout(carry[WIDTH]),
        .set(set_w), .ovf(overflow_o)
    );

    assign carry_o = carry[WIDTH];
    assign zero_o  = ~(|result_o);
endmodule

// File: rtl/bslice_alu_chk.sv
module bslice_alu_chk
    import bslice_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [OP_W-1:0]  op_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o,
    input logic             overflow_o,
    input logic             zero_o
);
    always_comb begin
        // R8
        zero_flag_chk: assert (zero_o == (result_o == '0));
        // R7
        no_overflow_chk: assert (!(op_i == OP_AND || op_i == OP_OR || op_i == OP_SLT) || !overflow_o);
        // R5
        slt_upper_chk: assert (op_i != OP_SLT || result_o[WIDTH-1:1] == '0);
        // R5
        slt_value_chk: assert (op_i != OP_SLT || result_o[0] == ($signed(a_i) < $signed(b_i)));
        // R3
        add_sum_chk: assert (op_i != OP_ADD || {carry_o, result_o} == ({1'b0, a_i} + {1'b0, b_i}));
        // R4
        sub_borrow_chk: assert (op_i != OP_SUB || carry_o == (a_i >= b_i));
        // R1
        and_chk: assert (op_i != OP_AND || result_o == (a_i & b_i));
    end
endmodule

bind bslice_alu bslice_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .a_i(a_i), .b_i(b_i), .op_i(op_i), .result_o(result_o),
    .carry_o(carry_o), .overflow_o(overflow_o), .zero_o(zero_o)
);

// File: tb/sim_bslice_alu.sv
`timescale 1ns/1ps
module sim_bslice_alu;
    import bslice_alu_pkg::*;

    localparam int W = 4;
    localparam int N = 1 << W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a, b, res;
    logic [3:0]   op;
    logic         cy, ov, zf;
    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    bslice_alu #(.WIDTH(W)) u0 (
        .a_i(a), .b_i(b), .op_i(op), .result_o(res),
        .carry_o(cy), .overflow_o(ov), .zero_o(zf)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s op=%b a=%0d b=%0d actual=%0d expected=%0d", req, op, a, b, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] o, input int x, input int y);
        @(negedge clk);
        op = o; a = x[W-1:0]; b = y[W-1:0];
        #2;
    endtask

    task automatic test_and();
        for (int x = 0; x < N; x++)
            for (int y = 0; y < N; y++) begin
                apply(4'b0000, x, y);
                check("R1 and", res, x & y);
                check("R7 and ovf", ov, 0);
                check("R8 zero", zf, ((x & y) == 0));
            end
    endtask

    task automatic test_or();
        for (int x = 0; x < N; x++)
            for (int y = 0; y < N; y++) begin
                apply(4'b0001, x, y);
                check("R2 or", res, x | y);
                check("R7 or ovf", ov, 0);
                check("R8 zero", zf, ((x | y) == 0));
            end
    endtask

    function automatic int sx(input int v);
        return (v >= N/2) ? v - N : v;
    endfunction

    task automatic test_add();
        for (int x = 0; x < N; x++)
            for (int y = 0; y < N; y++) begin
                int s = x + y;
                int ss = sx(x) + sx(y);
                apply(4'b0010, x, y);
                check("R3 sum", res, s % N);
                check("R3 carry", cy, s >= N);
                check("R6 add ovf", ov, (ss < -N/2) || (ss >= N/2));
                check("R8 zero", zf, (s % N) == 0);
            end
    endtask

    task automatic test_sub();
        for (int x = 0; x < N; x++)
            for (int y = 0; y < N; y++) begin
                int d = (x - y + N) % N;
                int sd = sx(x) - sx(y);
                apply(4'b0110, x, y);
                check("R4 diff", res, d);
                check("R4 carry", cy, x >= y);
                check("R6 sub ovf", ov, (sd < -N/2) || (sd >= N/2));
                check("R8 zero", zf, d == 0);
            end
    endtask

    task automatic test_slt();
        for (int x = 0; x < N; x++)
            for (int y = 0; y < N; y++) begin
                int lt = (sx(x) < sx(y)) ? 1 : 0;
                apply(4'b0111, x, y);
                check("R5 slt", res, lt);
                check("R7 slt ovf", ov, 0);
                check("R8 zero", zf, lt == 0);
            end
    endtask

    task automatic test_corners();
        apply(4'b0010, 7, 1);   check("R6 pos ovf", ov, 1);
        apply(4'b0110, 8, 1);   check("R6 neg ovf", ov, 1);
        apply(4'b0111, 8, 7);   check("R5 slt under ovf", res, 1);
        apply(4'b0111, 7, 8);   check("R5 slt under ovf", res, 0);
        apply(4'b0110, 5, 5);   check("R8 zero sub", zf, 1);
        apply(4'b0010, 9, 7);   check("R8 zero wrap", zf, 1);
    endtask

    initial begin
        op = 4'b0000; a = '0; b = '0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        #2;
        check("R8 idle zero", zf, 1);
        check("R7 idle ovf", ov, 0);
        test_and();
        test_or();
        test_add();
        test_sub();
        test_slt();
        test_corners();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule